// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a memory device's boundary-scan logic. It follows the sixteen-state controller walk defined by IEEE 1149.1, driven by the test clock `tck` and the mode select `tms`. It holds a three-bit instruction register, made of a shift stage and an update latch. It also holds three data registers: a single-bit bypass cell, a 32-bit identification word, and a boundary chain whose length is a parameter (54 cells by default). The instruction held in the latch decides which data register sits between `tdi` and `tdo`.

Serial data enters each register at bit 0 and leaves from the top bit. The test output is launched on the falling edge of `tck`, and its enable is high only while the controller is in one of the two shift states. Two instructions capture the device pin values into the boundary chain. One of them also raises `float_core` for as long as it is in force, so that the core can turn off its data and match drivers. The pin cells themselves belong to the surrounding design.

Top module: `scan_tap_ctrl`

## Requirements
- R1: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` and `tdo_oe` change only on the falling edge.
- R2: An active-low `trst_n` puts the controller in Test-Logic-Reset at once. Five consecutive rising edges with `tms`=1 also reach Test-Logic-Reset from any state. Four such edges taken from Pause-DR do not.
- R3: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. It is 0 in every other state and during reset.
- R4: Each register shifts toward its most significant bit. `tdi` enters bit 0 and the top bit drives `tdo`. The lengths are 3 (instruction), 1 (bypass), 32 (identification) and BSR_LEN (boundary). This is visible because `tdi` reappears on `tdo` after exactly that many shifts.
- R5: The data path is chosen by the instruction latch as follows: opcode 1 selects identification; opcodes 2 and 4 select the boundary chain; opcodes 0, 3, 5, 6 and 7 select bypass.
- R6: Capture-IR loads the binary pattern 001 into the instruction shift stage, so the first bits out are 0, 0, 1.
- R7: Entering Test-Logic-Reset loads opcode 1 into the instruction latch, so the identification word is the first data register read after reset.
- R8: The identification word has these fields: bit 0 = 1, bits 7:1 = ID_MFR, bits 11:8 = ID_BANK, bits 27:12 = ID_PART, bits 31:28 = ID_REV. The defaults are 7'h35, 4'h3, 16'h4A7C and 4'h1.
- R9: The bypass cell captures 0 in Capture-DR.
- R10: With opcode 2 or 4 in force, Capture-DR copies `pin_sample` into the boundary chain, with bit i going to cell i.
- R11: `float_core` is 1 exactly while the latch holds opcode 2. It rises on the edge that leaves Update-IR, and it falls on an update of another opcode or on reset.
- R12: The instruction latch changes only on leaving Update-IR or on entering Test-Logic-Reset. Shifting a new opcode into the shift stage does not alter the path or `float_core`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset (power-up) |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial test data in |
| pin_sample | input | BSR_LEN | Present device pin values for capture |
| tdo | output | 1 | Serial test data out, falling-edge launched |
| tdo_oe | output | 1 | Output enable for tdo (1 = drive) |
| float_core | output | 1 | Asks the core to float its data and match drivers |

## Verification
Two things fall on the same rising edge: the last bit of a shift and the exit from the shift state. The bench provokes this by raising `tms` on the final shift bit of every scan. It judges the outcome in two ways: the serial stream must carry exactly the register length before `tdi` reappears, and `tdo_oe` must already be low at the following falling edge.

A second collision is a pending opcode change in the shift stage at the moment the controller is forced to Test-Logic-Reset or enters Update-IR. The bench watches `float_core` at Exit1-IR, after the update, after four and after five high `tms` edges, and after an asynchronous reset.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_IDCODE   = 3'd1;
  localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'd2;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'd4;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {
    PATH_BYPASS, PATH_IDENT, PATH_BOUNDARY
  } dr_path_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return m ? ST_SEL_DR : ST_RTI;
      default:   return ST_TLR;
    endcase
  endfunction

  function automatic dr_path_t path_of(input logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:              return PATH_IDENT;
      OP_SAMPLE_Z, OP_SAMPLE: return PATH_BOUNDARY;
      default:                return PATH_BYPASS;
    endcase
  endfunction

  function automatic logic [31:0] id_word(input logic [6:0] mfr, input logic [3:0] bank,
                                          input logic [15:0] part, input logic [3:0] rev);
    return {rev, part, bank, mfr, 1'b1};
  endfunction

  function automatic logic is_shift(input tap_state_t s);
    return (s == ST_SH_DR) || (s == ST_SH_IR);
  endfunction

endpackage

// File: rtl/tap_state_fsm.sv
module tap_state_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state,
  output tap_state_t nxt_state
);

  assign nxt_state = tap_next(state, tms);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt_state;
  end

  // R2: five high tms edges always land in Test-Logic-Reset
  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == ST_TLR));

endmodule

// File: rtl/tap_shift_seg.sv
module tap_shift_seg #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         cap_en,
  input  logic         shf_en,
  input  logic [W-1:0] cap_val,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);

  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_single
      assign shifted = sin;
    end else begin : g_multi
      assign shifted = {q[W-2:0], sin};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     q <= RST_VAL;
    else if (cap_en) q <= cap_val;
    else if (shf_en) q <= shifted;
  end

  assign sout = q[W-1];

  // R4: new bit enters at position zero
  a_r4_enter_lsb: assert property (@(posedge tck) disable iff (!trst_n)
    (shf_en && !cap_en) |=> (q[0] == $past(sin)));

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_t      state,
  input  tap_state_t      nxt_state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_msb
);

  logic            cap_ir_ev;
  logic            sh_ir_ev;
  logic            upd_ir_ev;
  logic            tlr_ev;
  logic [IR_W-1:0] ir_shift_q;

  assign cap_ir_ev = (state == ST_CAP_IR);
  assign sh_ir_ev  = (state == ST_SH_IR);
  assign upd_ir_ev = (state == ST_UPD_IR);
  assign tlr_ev    = (nxt_state == ST_TLR);

  tap_shift_seg #(.W(IR_W), .RST_VAL(IR_CAPTURE)) u_ir_shift (
    .tck     (tck),
    .trst_n  (trst_n),
    .cap_en  (cap_ir_ev),
    .shf_en  (sh_ir_ev),
    .cap_val (IR_CAPTURE),
    .sin     (tdi),
    .q       (ir_shift_q),
    .sout    (ir_msb)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        ir_q <= OP_IDCODE;
    else if (tlr_ev)    ir_q <= OP_IDCODE;
    else if (upd_ir_ev) ir_q <= ir_shift_q;
  end

  // R6: capture pattern lands in the shift stage
  a_r6_capture_001: assert property (@(posedge tck) disable iff (!trst_n)
    cap_ir_ev |=> (ir_shift_q == 3'b001));

  // R7: latch holds identification opcode while in reset state
  a_r7_tlr_ident: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |-> (ir_q == OP_IDCODE));

  // R12: latch is untouched outside update and reset entry
  a_r12_latch_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_ir_ev && !tlr_ev) |=> $stable(ir_q));

endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs
  import tap_pkg::*;
#(
  parameter int          BSR_LEN = 54,
  parameter logic [31:0] ID_VAL  = 32'h1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_t         state,
  input  dr_path_t           path,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_sample,
  output logic               dr_msb
);

  logic               cap_dr_ev;
  logic               sh_dr_ev;
  logic [2:0]         sel;
  logic [2:0]         msb;
  logic [0:0]         byp_q;
  logic [31:0]        id_q;
  logic [BSR_LEN-1:0] bsr_q;

  assign cap_dr_ev = (state == ST_CAP_DR);
  assign sh_dr_ev  = (state == ST_SH_DR);
  assign sel[0]    = (path == PATH_BYPASS);
  assign sel[1]    = (path == PATH_IDENT);
  assign sel[2]    = (path == PATH_BOUNDARY);

  tap_shift_seg #(.W(1), .RST_VAL(1'b0)) u_bypass (
    .tck(tck), .trst_n(trst_n),
    .cap_en(cap_dr_ev && sel[0]), .shf_en(sh_dr_ev && sel[0]),
    .cap_val(1'b0), .sin(tdi), .q(byp_q), .sout(msb[0])
  );

  tap_shift_seg #(.W(32), .RST_VAL(32'h0)) u_ident (
    .tck(tck), .trst_n(trst_n),
    .cap_en(cap_dr_ev && sel[1]), .shf_en(sh_dr_ev && sel[1]),
    .cap_val(ID_VAL), .sin(tdi), .q(id_q), .sout(msb[1])
  );

  tap_shift_seg #(.W(BSR_LEN), .RST_VAL('0)) u_boundary (
    .tck(tck), .trst_n(trst_n),
    .cap_en(cap_dr_ev && sel[2]), .shf_en(sh_dr_ev && sel[2]),
    .cap_val(pin_sample), .sin(tdi), .q(bsr_q), .sout(msb[2])
  );

  always_comb begin
    dr_msb = msb[0];
    if (sel[1]) dr_msb = msb[1];
    if (sel[2]) dr_msb = msb[2];
  end

  // R9: bypass cell captures zero
  a_r9_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr_ev && sel[0]) |=> (byp_q == 1'b0));

  // R8: identification word has its fixed low bit after capture
  a_r8_id_lsb: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr_ev && sel[1]) |=> (id_q[0] == 1'b1));

  // R10: boundary chain holds the sampled pins after capture
  a_r10_pins_captured: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr_ev && sel[2]) |=> (bsr_q == $past(pin_sample)));

  // R5: exactly one data path selected
  a_r5_one_path: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(sel) && (sel != 3'b000));

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import tap_pkg::*;
#(
  parameter int          BSR_LEN = 54,
  parameter logic [6:0]  ID_MFR  = 7'h35,
  parameter logic [3:0]  ID_BANK = 4'h3,
  parameter logic [15:0] ID_PART = 16'h4A7C,
  parameter logic [3:0]  ID_REV  = 4'h1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               float_core
);

  localparam logic [31:0] ID_VAL = id_word(ID_MFR, ID_BANK, ID_PART, ID_REV);

  tap_state_t      state;
  tap_state_t      nxt_state;
  logic [IR_W-1:0] ir_q;
  logic            ir_msb;
  logic            dr_msb;
  dr_path_t        path;
  logic            shifting;
  logic            tdo_q;
  logic            oe_q;

  tap_state_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms),
    .state(state), .nxt_state(nxt_state)
  );

  tap_instr_reg u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .nxt_state(nxt_state),
    .tdi(tdi), .ir_q(ir_q), .ir_msb(ir_msb)
  );

  assign path = path_of(ir_q);

  tap_data_regs #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_VAL)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(state), .path(path),
    .tdi(tdi), .pin_sample(pin_sample), .dr_msb(dr_msb)
  );

  assign shifting = is_shift(state);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= shifting;
      tdo_q <= (state == ST_SH_IR) ? ir_msb : dr_msb;
    end
  end

  assign tdo        = tdo_q;
  assign tdo_oe     = oe_q;
  assign float_core = (ir_q == OP_SAMPLE_Z);

  // R3: enable seen at a rising edge reflects the state held before it
  a_r3_oe_shift_only: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == is_shift(state));

  // R11: float request starts only on leaving Update-IR
  a_r11_float_from_update: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(float_core) |-> ($past(state) == ST_UPD_IR));

endmodule

// File: tb/scan_tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module scan_tap_ctrl_tb_top;

  localparam int BL = 54;
  localparam logic [31:0] EXP_ID = {4'h1, 16'h4A7C, 4'h3, 7'h35, 1'b1};

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic [BL-1:0] pin_sample = '0;
  logic          tdo, tdo_oe, float_core;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  started = 1'b0;
  bit  last_neg;
  bit  exp_q[$];
  string cur_tag = "R4";

  scan_tap_ctrl dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .pin_sample(pin_sample), .tdo(tdo), .tdo_oe(tdo_oe), .float_core(float_core)
  );

  always #4 tck = ~tck;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops expected serial bits while tdo is enabled
  always begin
    @(negedge tck); #2;
    last_neg = tdo;
    if (started && tdo_oe === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected shift", 64'(tdo), 64'h0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(tdo === e, cur_tag, 64'(tdo), 64'(e));
      end
    end
  end

  // R1: tdo never moves at the rising edge
  always begin
    @(posedge tck); #1;
    if (started) chk(tdo === last_neg, "R1", 64'(tdo), 64'(last_neg));
  end

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_stream(input int len, input logic [127:0] cap,
                              input int n, input logic [127:0] d, input string tag);
    cur_tag = tag;
    for (int k = 0; k < n; k++)
      exp_q.push_back(k < len ? cap[len-1-k] : d[k-len]);
    for (int k = 0; k < n; k++) tick(k == n-1, d[k]);
  endtask

  task automatic load_ir(input logic [2:0] op);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    shift_stream(3, 128'b001, 3, {125'b0, op[0], op[1], op[2]}, "R6");
  endtask

  task automatic commit_ir;
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int len, input logic [127:0] cap, input int n,
                         input logic [127:0] d, input string tag);
    tick(1, 0); tick(0, 0); tick(0, 0);
    shift_stream(len, cap, n, d, tag);
    chk(tdo_oe == 1'b0, "R3 oe after exit", 64'(tdo_oe), 64'h0);
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 64'h0, 64'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] byp_ops [5] = '{3'd0, 3'd3, 3'd5, 3'd6, 3'd7};
    repeat (3) @(negedge tck);
    #1;
    chk(tdo_oe == 1'b0, "R3 reset oe", 64'(tdo_oe), 64'h0);
    chk(float_core == 1'b0, "R11 reset float", 64'(float_core), 64'h0);
    trst_n = 1'b1;
    started = 1'b1;
    tick(1, 0);
    tick(0, 0);
    // R7 and R8: identification word first after reset, 32 bits long
    scan_dr(32, 128'(EXP_ID), 36, 128'hB, "R8");
    // R6 and R9: bypass captures 0 and is one bit long
    load_ir(3'd0); commit_ir();
    scan_dr(1, 128'h0, 6, 128'h2D, "R9");
    // R5: every bypass opcode
    foreach (byp_ops[i]) begin
      load_ir(byp_ops[i]); commit_ir();
      scan_dr(1, 128'h0, 4, 128'hA, "R5");
      chk(float_core == 1'b0, "R5 no float", 64'(float_core), 64'h0);
    end
    // R10: sample captures pins, chain length BSR_LEN
    pin_sample = 54'h15AF0C39E17B4D;
    load_ir(3'd4); commit_ir();
    chk(float_core == 1'b0, "R11 sample no float", 64'(float_core), 64'h0);
    scan_dr(BL, 128'(pin_sample), BL + 3, 128'h5, "R10");
    pin_sample = 54'h2C35A960FF1E28;
    scan_dr(BL, 128'(pin_sample), BL, 128'h0, "R10");
    // R12: new opcode shifted but not yet updated
    load_ir(3'd2);
    chk(float_core == 1'b0, "R12 float before update", 64'(float_core), 64'h0);
    tick(1, 0);
    chk(float_core == 1'b0, "R12 float in update", 64'(float_core), 64'h0);
    tick(0, 0);
    chk(float_core == 1'b1, "R11 float after update", 64'(float_core), 64'h1);
    pin_sample = 54'h0F0F0F0F0F0F0F;
    scan_dr(BL, 128'(pin_sample), BL, 128'h0, "R10");
    // R2: four ones from Pause-DR do not reset, the fifth does
    tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
    chk(float_core == 1'b1, "R2 four ones", 64'(float_core), 64'h1);
    tick(1, 0);
    chk(float_core == 1'b0, "R2 five ones", 64'(float_core), 64'h0);
    tick(0, 0);
    scan_dr(32, 128'(EXP_ID), 32, 128'h0, "R7");
    // R2: asynchronous reset clears a pending sample-and-float
    load_ir(3'd2); commit_ir();
    chk(float_core == 1'b1, "R11 float set", 64'(float_core), 64'h1);
    trst_n = 1'b0; #2;
    chk(float_core == 1'b0, "R2 async reset", 64'(float_core), 64'h0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    tick(0, 0);
    scan_dr(32, 128'(EXP_ID), 32, 128'h0, "R7");
    chk(exp_q.size() == 0, "R4 stream drained", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule